// File: doc/BRIEF.md
# Dual-Lane Lookup-Table Symbol Encoder with Running Balance

This block turns colour pixels into 10-bit transition-minimised symbols at full horizontal resolution, without computing the symbol logic per pixel. Each pixel's colour code, joined with the sign of a running balance counter, selects one word from a lookup table. The word carries the symbol value in its low bits and a signed balance increment in its top bits. The whole word is added back into that lane's counter, so the next lookup in the lane can pick the variant of the symbol that pulls the balance back toward zero. The symbol/increment table is computed elsewhere and loaded through a write port. That precomputation, serialisation and control periods are not part of this block.

Even-position and odd-position pixels travel through two separate lanes, each with its own counter. Every lane's stream is DC balanced on its own. The interleaved result is intentionally different from the textbook single-stream encoder. A feedback-disable input freezes both counters at fixed starting values, and a palette mode packs two 10-bit symbols into one output word for paletted frame buffers. One pixel pair is accepted every clock. The lane sign is forwarded, so a pixel right behind another in the same lane already sees the updated balance.

Top module: `tmds_lut_encoder`

## Requirements
- R1: After reset `out_valid` is low. With `fb_en` high during reset, both lane counters start at zero, so the first lookups use sign 0.
- R2: A cycle with `tbl_we` high stores `tbl_data` at `tbl_addr`, and later lookups of that index return it. Writes are only made while `pix_valid` is low.
- R3: A lane's 7-bit table index is {sign, colour}. Bit 6 is bit 47 (the sign) of the lane's running sum and bits 5:0 are the colour. Lane 0 takes `pix_in[5:0]`. Lane 1 takes `pix_in[21:16]` in direct mode and `pix_in[13:8]` in palette mode. All other input bits are ignored.
- R4: `out_valid` rises exactly one clock after an accepted pixel pair, one result per pair, in order, with no gaps added for back-to-back pairs.
- R5: In direct mode (`pal_mode` low), `out_data[19:0]` is bits 19:0 of the lane 0 entry and `out_data[39:20]` is bits 19:0 of the lane 1 entry.
- R6: A table word is laid out as balance field [47:36], zero guard [35:20] and symbol [19:0]. With `fb_en` high, each lookup adds the full 48-bit word to that lane's counter, modulo 2^48. A pixel in the very next cycle uses the updated sign.
- R7: The two lanes' counters are independent. Lane 0 lookups never change lane 1's sign, and lane 1 lookups never change lane 0's sign.
- R8: A `line_start` pulse loads both counters with their starting values. A pixel pair presented in the same cycle already uses those values, and any entry still in flight from before is not counted.
- R9: With `fb_en` low, the starting values are zero for lane 0 and all ones for lane 1, and no lookup changes them. After a `line_start`, even lookups therefore use sign 0 and odd lookups use sign 1.
- R10: In palette mode, `out_data` is {20 zero bits, lane 1 entry[9:0], lane 0 entry[9:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Table write index |
| tbl_data | input | 48 | Table word to write |
| fb_en | input | 1 | Balance feedback enable |
| pal_mode | input | 1 | Palette packing and pixel layout select |
| line_start | input | 1 | Start-of-line pulse, reloads counters |
| pix_valid | input | 1 | Pixel pair present |
| pix_in | input | 32 | Pixel pair |
| out_valid | output | 1 | Result valid |
| out_data | output | 40 | Symbol pair |

## Verification
Long back-to-back runs with random colours and feedback on make the counters cross zero often. A design that forwards a stale sign then picks the wrong table half, and the symbol differs. Alternating busy and idle cycles separates the forwarding path from the plain registered counter, and shows any latency error. Line starts placed alone and on the same cycle as a pixel expose counters that are not reloaded, or are reloaded one cycle late. Palette runs with random noise in the ignored bytes, and no-feedback runs where lane 1 must always use the high table half, check the pixel field selection and the fixed starting values.

// File: rtl/tmds_lut_pkg.sv
package tmds_lut_pkg;
    localparam int SYM_W     = 20;
    localparam int GUARD_W   = 16;
    localparam int BAL_W     = 12;
    localparam int ENTRY_W   = SYM_W + GUARD_W + BAL_W;
    localparam int COLOR_W   = 6;
    localparam int IDX_W     = COLOR_W + 1;
    localparam int DEPTH     = 1 << IDX_W;
    localparam int PAL_SYM_W = 10;
    localparam int LANES     = 2;
    localparam int OUT_W     = LANES * SYM_W;

    typedef struct packed {
        logic               neg;
        logic [COLOR_W-1:0] color;
    } lut_idx_t;

    function automatic logic [ENTRY_W-1:0] lane_start_value(input logic fb_en, input int lane);
        return (!fb_en && lane == 1) ? '1 : '0;
    endfunction
endpackage

// File: rtl/tmds_lut_ram.sv
module tmds_lut_ram #(
    parameter int W     = 48,
    parameter int DEPTH = 128,
    parameter int PORTS = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [W-1:0]             wdata,
    input  logic [PORTS-1:0][AW-1:0] raddr,
    output logic [PORTS-1:0][W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            rdata[p] <= mem[raddr[p]];
        end
    end
endmodule

// File: rtl/tmds_lane_acc.sv
module tmds_lane_acc #(
    parameter int ENTRY_W = 48,
    parameter int LANE    = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fb_en,
    input  logic               line_start,
    input  logic               add_en,
    input  logic [ENTRY_W-1:0] add_val,
    output logic               sign_o
);
    import tmds_lut_pkg::*;

    logic [ENTRY_W-1:0] acc_q, start_v, sum;

    assign start_v = ENTRY_W'(lane_start_value(fb_en, LANE));

    always_comb begin
        if (line_start)          sum = start_v;
        else if (fb_en && add_en) sum = acc_q + add_val;
        else                     sum = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= start_v;
        else     acc_q <= sum;
    end

    assign sign_o = sum[ENTRY_W-1];

    assert_line_reload_R8: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (acc_q == $past(start_v)));
    assert_nofb_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (!fb_en && !line_start) |=> $stable(acc_q));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!add_en && !line_start) |=> $stable(acc_q));
endmodule

// File: rtl/tmds_lut_encoder.sv
module tmds_lut_encoder #(
    parameter int PIX_W       = 32,
    parameter int ODD_OFS_DIR = 16,
    parameter int ODD_OFS_PAL = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               tbl_we,
    input  logic [tmds_lut_pkg::IDX_W-1:0]     tbl_addr,
    input  logic [tmds_lut_pkg::ENTRY_W-1:0]   tbl_data,
    input  logic                               fb_en,
    input  logic                               pal_mode,
    input  logic                               line_start,
    input  logic                               pix_valid,
    input  logic [PIX_W-1:0]                   pix_in,
    output logic                               out_valid,
    output logic [tmds_lut_pkg::OUT_W-1:0]     out_data
);
    import tmds_lut_pkg::*;

    logic [LANES-1:0]              lane_sign;
    lut_idx_t [LANES-1:0]          lane_idx;
    logic [LANES-1:0][IDX_W-1:0]   raddr;
    logic [LANES-1:0][ENTRY_W-1:0] rdata;
    logic                          s1_valid, s1_pal;
    logic                          unused_pix_bits;

    assign unused_pix_bits = ^{pix_in[PIX_W-1:ODD_OFS_DIR+COLOR_W],
                               pix_in[ODD_OFS_DIR-1:ODD_OFS_PAL+COLOR_W],
                               pix_in[ODD_OFS_PAL-1:COLOR_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_pal   <= 1'b0;
        end else begin
            s1_valid <= pix_valid;
            s1_pal   <= pal_mode;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tmds_lane_acc #(.ENTRY_W(ENTRY_W), .LANE(l)) i_acc (
            .clk        (clk),
            .rst        (rst),
            .fb_en      (fb_en),
            .line_start (line_start),
            .add_en     (s1_valid),
            .add_val    (rdata[l]),
            .sign_o     (lane_sign[l])
        );
        assign lane_idx[l].neg = lane_sign[l];
        if (l == 0) begin : g_even
            assign lane_idx[l].color = pix_in[COLOR_W-1:0];
        end else begin : g_odd
            assign lane_idx[l].color = pal_mode ? pix_in[ODD_OFS_PAL +: COLOR_W]
                                                : pix_in[ODD_OFS_DIR +: COLOR_W];
        end
        assign raddr[l] = lane_idx[l];
    end

    tmds_lut_ram #(.W(ENTRY_W), .DEPTH(DEPTH), .PORTS(LANES)) i_ram (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    always_comb begin
        if (s1_pal)
            out_data = {{(OUT_W-2*PAL_SYM_W){1'b0}},
                        rdata[1][PAL_SYM_W-1:0], rdata[0][PAL_SYM_W-1:0]};
        else
            out_data = {rdata[1][SYM_W-1:0], rdata[0][SYM_W-1:0]};
    end

    assign out_valid = s1_valid;

    assert_write_idle_R2: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> !pix_valid);
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);
    assert_pal_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pal_mode) |=> (out_data[OUT_W-1:2*PAL_SYM_W] == '0));
endmodule

// File: tb/test_tmds_lut_encoder.sv
module test_tmds_lut_encoder;
    logic        clk = 1'b0;
    logic        rst, tbl_we, fb_en, pal_mode, line_start, pix_valid;
    logic [6:0]  tbl_addr;
    logic [47:0] tbl_data;
    logic [31:0] pix_in;
    logic        out_valid;
    logic [39:0] out_data;

    tmds_lut_encoder i_tmds_lut_encoder (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .fb_en(fb_en), .pal_mode(pal_mode), .line_start(line_start),
        .pix_valid(pix_valid), .pix_in(pix_in), .out_valid(out_valid), .out_data(out_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [39:0] data;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [47:0] tbl [128];
    logic [47:0] acc_m [2];
    int          cyc = 0;
    int          vectors = 0;
    int          misses = 0;

    function automatic logic [47:0] make_entry(input int idx);
        logic [5:0] mag, d;
        logic [19:0] sym;
        mag = 6'((idx % 5) * 2);
        d   = idx[6] ? mag : (~mag + 6'd1);
        sym = {7'(idx), 13'(idx * 97 + 3)};
        return {d, 6'b0, 16'b0, sym};
    endfunction

    function automatic logic [47:0] start_m(input logic fb, input int lane);
        return (!fb && lane == 1) ? '1 : '0;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_entry(input int idx, input logic [47:0] val);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 7'(idx); tbl_data = val;
        tbl[idx] = val;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic beat(input logic v, input logic ls, input logic [31:0] p, input string tag);
        logic [5:0]  col [2];
        logic [47:0] e [2];
        exp_t        x;
        @(negedge clk);
        pix_valid = v; line_start = ls; pix_in = p;
        if (ls) begin
            acc_m[0] = start_m(fb_en, 0);
            acc_m[1] = start_m(fb_en, 1);
        end
        if (v) begin
            col[0] = p[5:0];
            col[1] = pal_mode ? p[13:8] : p[21:16];
            for (int l = 0; l < 2; l++) begin
                e[l] = tbl[{acc_m[l][47], col[l]}];
                if (fb_en) acc_m[l] = acc_m[l] + e[l];
            end
            x.data = pal_mode ? {20'b0, e[1][9:0], e[0][9:0]} : {e[1][19:0], e[0][19:0]};
            x.cyc  = cyc + 1;
            x.tag  = tag;
            q.push_back(x);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R4 unexpected output", out_data, '0);
            end else begin
                exp_t x;
                x = q.pop_front();
                check(x.cyc == cyc, {x.tag, " R4 timing"}, 40'(cyc), 40'(x.cyc));
                check(out_data == x.data, x.tag, out_data, x.data);
            end
        end
    end

    initial begin
        rst = 1'b1; tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
        fb_en = 1'b1; pal_mode = 1'b0; line_start = 1'b0; pix_valid = 1'b0; pix_in = '0;
        acc_m[0] = '0; acc_m[1] = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", 40'(out_valid), 40'd0);
        rst = 1'b0;
        for (int i = 0; i < 128; i++) write_entry(i, make_entry(i));
        // R1: counters start at zero without any line start
        beat(1'b1, 1'b0, 32'h0003_0007, "R1 first lookup");
        // R6 R3 R5: back-to-back random pixels with feedback
        for (int i = 0; i < 60; i++) beat(1'b1, 1'b0, $urandom, "R6 back-to-back");
        // R4: gapped pixels
        for (int i = 0; i < 20; i++) begin
            beat(1'b1, 1'b0, $urandom, "R4 gapped");
            beat(1'b0, 1'b0, $urandom, "R4 idle");
        end
        // R7: lane 0 fixed colour, lane 1 varied
        for (int i = 0; i < 30; i++) beat(1'b1, 1'b0, {10'h0, 6'(i * 7), 10'h0, 6'h15}, "R7 lane independence");
        // R8: line start alone and together with a pixel
        beat(1'b0, 1'b1, '0, "R8 line start");
        for (int i = 0; i < 10; i++) beat(1'b1, 1'b0, $urandom, "R8 after line start");
        beat(1'b1, 1'b1, $urandom, "R8 line start with pixel");
        for (int i = 0; i < 10; i++) beat(1'b1, 1'b0, $urandom, "R8 new line");
        // R10 R3: palette mode with noise in ignored bits
        @(negedge clk); pix_valid = 1'b0; pal_mode = 1'b1;
        for (int i = 0; i < 30; i++) beat(1'b1, 1'b0, $urandom, "R10 palette");
        // R9: no feedback
        @(negedge clk); pix_valid = 1'b0; pal_mode = 1'b0; fb_en = 1'b0;
        beat(1'b0, 1'b1, '0, "R9 line start");
        for (int i = 0; i < 30; i++) beat(1'b1, 1'b0, $urandom, "R9 no feedback");
        // R2: overwrite an entry and use it
        @(negedge clk); pix_valid = 1'b0;
        write_entry(64 + 9, 48'h0000_0000_ABCDE);
        beat(1'b1, 1'b0, 32'h0009_0009, "R2 rewritten entry");
        fb_en = 1'b1;
        beat(1'b0, 1'b1, '0, "R8 line start");
        for (int i = 0; i < 20; i++) beat(1'b1, 1'b0, $urandom, "R6 feedback again");
        @(negedge clk); pix_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R4 all results seen", 40'(q.size()), 40'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule